// File: doc/BRIEF.md
# Interrupt Arbiter for a Three-Level Hart

The arbiter decides, from the current privilege state of a hart, whether a pending interrupt must be taken now and which line wins. It receives the raw pending vector and the enable vector, two delegation masks (one handing lines from machine level to supervisor level, one handing lines from supervisor level on to a virtualised guest), the current privilege, a virtualisation flag, the machine and supervisor global enables, a non-maskable-interrupt enable and a debug-mode flag. All CSR storage is outside the block; these values arrive as plain inputs.

Three tiers are examined in a fixed order: machine, then host supervisor, then guest. The first tier that yields an enabled line supplies the candidate set. Within that set, custom lines (index 14 and up) beat every standard line, and the standard lines follow a fixed ranking that does not follow their numeric order. The result is registered: one cycle after the inputs are sampled, a take strobe, an encoded cause word and a wake signal for a core that sits in a wait-for-interrupt state appear at the outputs.

Top module: `irq_arbiter`

## Requirements
- R1: The effective pending set is pend_i AND en_i. Lines not set in mdeleg_i target machine level and are enabled when priv_i is below machine (encoding U=0, S=1, M=3) or when priv_i is machine with m_ie_i high.
- R2: Only when no machine-tier line is enabled, lines set in mdeleg_i and clear in gdeleg_i are considered; they are enabled when virt_i is high, when priv_i is U, or when priv_i is S with s_ie_i high.
- R3: Only when virt_i is high and neither higher tier produced an enabled line, lines set in gdeleg_i are considered; they are enabled when priv_i is U, or when priv_i is S with s_ie_i high.
- R4: Any candidate line at index 14 or above beats all standard lines; among several such lines the lowest index is reported.
- R5: Among standard lines the ranking, highest first, is 11, 3, 7, 9, 1, 5, 13, 10, 2, 6.
- R6: Candidate lines 0, 4, 8 and 12 rank below all others; the lowest of them is reported.
- R7: No interrupt is taken while dbg_i is high or while nmi_en_i is low.
- R8: When take_o is high, cause_o has bit CAUSE_W-1 set and its low bits hold the index of the selected line; when take_o is low, cause_o is zero.
- R9: wake_o is high one cycle after pend_i is nonzero, whether or not the line is enabled or taken.
- R10: Outputs reflect the inputs of the previous clock edge, so a one-cycle input pulse gives exactly one cycle of take_o.
- R11: While rst is high at a clock edge, take_o, cause_o and wake_o become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | IRQ_W | Raw pending lines |
| en_i | input | IRQ_W | Per-line enables |
| mdeleg_i | input | IRQ_W | Machine-to-supervisor delegation mask |
| gdeleg_i | input | IRQ_W | Supervisor-to-guest delegation mask |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Hart runs virtualised |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| nmi_en_i | input | 1 | Non-maskable-interrupt enable; low blocks all takes |
| dbg_i | input | 1 | Hart is in debug mode |
| take_o | output | 1 | Take an interrupt now |
| cause_o | output | CAUSE_W | Interrupt cause word |
| wake_o | output | 1 | End wait-for-interrupt |

## Verification
The assertions watch, on every cycle, the shape of the cause word, that a take never follows a cycle in debug mode, with the non-maskable enable low or with no enabled pending line, that a take always comes with wake, and that wake follows any nonzero pending input. Which tier wins, the non-numeric standard ranking, the dominance of custom lines and the fallback for lines 0, 4, 8 and 12 are shown only by the bench's directed scenarios and its long stream of random states compared against the reference model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        priv_e priv;
        logic  virt;
        logic  m_ie;
        logic  s_ie;
    } hart_ctx_t;

    typedef enum logic [1:0] {
        TIER_NONE = 2'd0,
        TIER_M    = 2'd1,
        TIER_HS   = 2'd2,
        TIER_VS   = 2'd3
    } tier_e;

    localparam int CUSTOM_LSB = 14;
    localparam int STD_N      = 10;

    // Standard line occupying a given rank, rank 0 is the strongest.
    function automatic int std_line(input int rank);
        case (rank)
            0:       return 11;
            1:       return 3;
            2:       return 7;
            3:       return 9;
            4:       return 1;
            5:       return 5;
            6:       return 13;
            7:       return 10;
            8:       return 2;
            default: return 6;
        endcase
    endfunction

    function automatic logic is_ranked(input int line);
        case (line)
            1, 2, 3, 5, 6, 7, 9, 10, 11, 13: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_tier_sel.sv
module irq_tier_sel
    import irq_arb_pkg::*;
#(
    parameter int IRQ_W = 16
) (
    input  logic [IRQ_W-1:0] act_i,
    input  logic [IRQ_W-1:0] mdeleg_i,
    input  logic [IRQ_W-1:0] gdeleg_i,
    input  hart_ctx_t        ctx_i,
    output logic [IRQ_W-1:0] cand_o,
    output tier_e            tier_o
);
    logic m_on, hs_on, vs_on;
    logic [IRQ_W-1:0] m_en, hs_en, vs_en;

    always_comb begin
        m_on  = (ctx_i.priv != PRIV_M) || ctx_i.m_ie;
        hs_on = ctx_i.virt || (ctx_i.priv == PRIV_U) ||
                ((ctx_i.priv == PRIV_S) && ctx_i.s_ie);
        vs_on = ctx_i.virt && ((ctx_i.priv == PRIV_U) ||
                ((ctx_i.priv == PRIV_S) && ctx_i.s_ie));

        m_en  = act_i & ~mdeleg_i & {IRQ_W{m_on}};
        hs_en = act_i & mdeleg_i & ~gdeleg_i & {IRQ_W{hs_on}};
        vs_en = act_i & gdeleg_i & {IRQ_W{vs_on}};

        if (|m_en) begin
            cand_o = m_en;
            tier_o = TIER_M;
        end else if (|hs_en) begin
            cand_o = hs_en;
            tier_o = TIER_HS;
        end else if (|vs_en) begin
            cand_o = vs_en;
            tier_o = TIER_VS;
        end else begin
            cand_o = '0;
            tier_o = TIER_NONE;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int IRQ_W = 16,
    parameter int IDX_W = $clog2(IRQ_W)
) (
    input  logic [IRQ_W-1:0] cand_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Later loops override earlier ones, so the strongest class is last.
    always_comb begin
        idx_o   = '0;
        valid_o = |cand_i;
        for (int i = CUSTOM_LSB - 1; i >= 0; i--) begin
            if (i < IRQ_W && !is_ranked(i) && cand_i[i])
                idx_o = IDX_W'(i);
        end
        for (int r = STD_N - 1; r >= 0; r--) begin
            if (std_line(r) < IRQ_W && cand_i[std_line(r)])
                idx_o = IDX_W'(std_line(r));
        end
        for (int i = IRQ_W - 1; i >= CUSTOM_LSB; i--) begin
            if (cand_i[i])
                idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int IRQ_W   = 16,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IRQ_W-1:0]   pend_i,
    input  logic [IRQ_W-1:0]   en_i,
    input  logic [IRQ_W-1:0]   mdeleg_i,
    input  logic [IRQ_W-1:0]   gdeleg_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic               m_ie_i,
    input  logic               s_ie_i,
    input  logic               nmi_en_i,
    input  logic               dbg_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               wake_o
);
    localparam int IDX_W = $clog2(IRQ_W);
    localparam int PAD_W = CAUSE_W - 1 - IDX_W;

    hart_ctx_t        ctx;
    logic [IRQ_W-1:0] cand;
    tier_e            tier;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             take_d;

    always_comb begin
        ctx.priv = priv_e'(priv_i);
        ctx.virt = virt_i;
        ctx.m_ie = m_ie_i;
        ctx.s_ie = s_ie_i;
    end

    irq_tier_sel #(.IRQ_W(IRQ_W)) u_tier (
        .act_i    (pend_i & en_i),
        .mdeleg_i (mdeleg_i),
        .gdeleg_i (gdeleg_i),
        .ctx_i    (ctx),
        .cand_o   (cand),
        .tier_o   (tier)
    );

    irq_prio_pick #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_pick (
        .cand_i  (cand),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    assign take_d = pick_valid && (tier != TIER_NONE) && nmi_en_i && !dbg_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o  <= 1'b0;
            cause_o <= '0;
            wake_o  <= 1'b0;
        end else begin
            take_o  <= take_d;
            cause_o <= take_d ? {1'b1, {PAD_W{1'b0}}, pick_idx} : '0;
            wake_o  <= |pend_i;
        end
    end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int IRQ_W   = 16,
    parameter int CAUSE_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [IRQ_W-1:0]   pend_i,
    input logic [IRQ_W-1:0]   en_i,
    input logic               nmi_en_i,
    input logic               dbg_i,
    input logic               take_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               wake_o
);
    a_r8_cause_msb: assert property (@(posedge clk) disable iff (rst)
        take_o |-> cause_o[CAUSE_W-1]);

    a_r8_cause_idle: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (cause_o == '0));

    a_r8_index_range: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (cause_o[CAUSE_W-2:0] < IRQ_W));

    a_r7_blocked: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(nmi_en_i && !dbg_i));

    a_r1_needs_pending: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(|(pend_i & en_i)));

    a_r9_take_wakes: assert property (@(posedge clk) disable iff (rst)
        take_o |-> wake_o);

    a_r9_wake_follows: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(|pend_i)) |-> wake_o);
endmodule

bind irq_arbiter irq_arb_chk #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend_i),
    .en_i     (en_i),
    .nmi_en_i (nmi_en_i),
    .dbg_i    (dbg_i),
    .take_o   (take_o),
    .cause_o  (cause_o),
    .wake_o   (wake_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    localparam int W  = 16;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  pend = '0, en = '0, md = '0, gd = '0;
    logic [1:0]    priv = 2'd3;
    logic          virt = 0, mie = 0, sie = 0, nmie = 1, dbg = 0;
    logic          take;
    logic [CW-1:0] cause;
    logic          wake;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_arbiter #(.IRQ_W(W), .CAUSE_W(CW)) u0 (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .mdeleg_i(md),
        .gdeleg_i(gd), .priv_i(priv), .virt_i(virt), .m_ie_i(mie),
        .s_ie_i(sie), .nmi_en_i(nmie), .dbg_i(dbg),
        .take_o(take), .cause_o(cause), .wake_o(wake)
    );

    // Reference model: returns the winning line, or -1 for none.
    function automatic int ref_pick();
        int rank_list[10] = '{11, 3, 7, 9, 1, 5, 13, 10, 2, 6};
        logic [W-1:0] a, c;
        bit m_ok, h_ok, g_ok;
        a    = pend & en;
        m_ok = (priv != 2'd3) || mie;
        h_ok = virt || (priv == 2'd0) || (priv == 2'd1 && sie);
        g_ok = (priv == 2'd0) || (priv == 2'd1 && sie);
        c = m_ok ? (a & ~md) : '0;
        if (c == 0) c = h_ok ? (a & md & ~gd) : '0;
        if (c == 0 && virt) c = g_ok ? (a & gd) : '0;
        if (c == 0 || dbg || !nmie) return -1;
        for (int i = 14; i < W; i++) if (c[i]) return i;
        foreach (rank_list[k]) if (c[rank_list[k]]) return rank_list[k];
        for (int i = 0; i < 14; i++) if (c[i]) return i;
        return -1;
    endfunction

    task automatic cmp(input string tag, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Inputs are set before the call at a falling edge; outputs are compared
    // at the next falling edge, after the one register stage.
    task automatic step(input string tag);
        int w;
        logic [CW-1:0] ec;
        logic et, ew;
        w  = ref_pick();
        et = (w >= 0);
        ec = et ? (32'h8000_0000 | CW'(w)) : '0;
        ew = (pend != 0);
        @(negedge clk);
        cmp(tag, CW'(take), CW'(et), "take");
        cmp(tag, cause, ec, "cause");
        cmp(tag, CW'(wake), CW'(ew), "wake");
    endtask

    task automatic clr();
        pend = '0; en = '1; md = '0; gd = '0; priv = 2'd3;
        virt = 0; mie = 1; sie = 0; nmie = 1; dbg = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pend = '1; en = '1;
        repeat (3) @(negedge clk);
        // R11: reset clears outputs even with lines pending
        cmp("R11", CW'(take), 0, "take");
        cmp("R11", cause, 0, "cause");
        cmp("R11", CW'(wake), 0, "wake");
        clr();
        rst = 0;
        step("R11");

        // R1: machine tier and its enable
        clr(); pend = 16'h0080; step("R1");
        mie = 0; step("R1");
        priv = 2'd1; step("R1");
        // R2: supervisor tier
        clr(); pend = 16'h0020; md = 16'h0020; priv = 2'd1; sie = 1; step("R2");
        sie = 0; step("R2");
        priv = 2'd3; step("R2");
        clr(); pend = 16'h00A0; md = 16'h0020; priv = 2'd1; sie = 1; step("R2");
        // R3: guest tier
        clr(); pend = 16'h0400; md = 16'h0400; gd = 16'h0400;
        priv = 2'd1; virt = 1; sie = 1; step("R3");
        sie = 0; step("R3");
        virt = 0; sie = 1; step("R3");
        priv = 2'd0; virt = 1; step("R3");
        // R4: custom lines dominate
        clr(); pend = 16'hC800; step("R4");
        pend = 16'h8002; step("R4");
        // R5: standard ranking
        clr(); pend = 16'h0808; step("R5");
        pend = 16'h2204; step("R5");
        pend = 16'h0444; step("R5");
        // R6: unranked lines last
        clr(); pend = 16'h2010; step("R6");
        pend = 16'h1110; step("R6");
        // R7: debug and NMI enable block takes
        clr(); pend = 16'h0800; dbg = 1; step("R7");
        dbg = 0; nmie = 0; step("R7");
        // R9: wake without a take
        clr(); pend = 16'h0800; en = '0; step("R9");
        // R10: one-cycle pulse gives one-cycle strobe
        clr(); pend = 16'h0008; step("R10");
        pend = '0; step("R10");
        // R8: cause format across random states
        for (int n = 0; n < 3000; n++) begin
            pend = W'($urandom); en = W'($urandom | $urandom);
            md = W'($urandom); gd = W'($urandom) & md;
            virt = $urandom_range(0, 1);
            priv = virt ? 2'($urandom_range(0, 1)) : 2'($urandom_range(0, 3));
            if (priv == 2'd2) priv = 2'd3;
            mie = $urandom_range(0, 1); sie = $urandom_range(0, 1);
            nmie = ($urandom_range(0, 7) != 0); dbg = ($urandom_range(0, 7) == 0);
            step("R8");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule